// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-facing side of a minimal serial port. A word-addressed bus with separate read and write strobes reaches a small set of 16-bit control, status and divider registers, a single receive holding word and a transmit data port. A write to the transmit port sends the low byte out immediately on a valid strobe. Incoming characters and line-break events arrive on a valid/ready byte handshake and sit in one holding word until software reads them.

The status registers keep the ready and empty indications and a fixed set of write-one-to-clear event bits. Writing control register 2 with its reset bit at zero performs a soft reset of the whole block. One level-sensitive interrupt line combines the receive-ready and transmit-ready conditions with their enables. The divider, one-millisecond and FIFO-control registers only hold what software writes. No bit timing is generated.

Top module: `serport_csr`

## Requirements
- R1: After hardware reset, reads return: status 1 (word 0x25) = 0x6040 (transmit-ready bit 13, RTS-state bit 14, receiver-idle bit 6); status 2 (0x26) = 0x4028 (transmit-empty bit 14, transmit-done bit 3, DCD-in bit 5); test register (0x2D) = 0x0060 (receive-empty bit 5, transmit-empty bit 6); control 3 (0x22) = 0x0700; baud count (0x2B) = 0x0004; receive data (0x00) = 0x4000 (error flag, bit 14); all other registers 0; irq low, rx_ready high, tx_valid low.
- R2: irq is high exactly when (status1 bit 9 and control1 bit 9) or (status1 bit 13 and control1 bit 13 and control1 bit 6).
- R3: Reading word 0x00 returns the held word; while a character is held the read value also has bit 15 set, and a read strobe then clears status1 bit 9 and status2 bit 0 and sets test bit 5, so the next read returns the held word without bit 15.
- R4: A write to control 2 (0x21) with bit 0 at zero returns every register and the receive holding word to the soft defaults (the R1 values, except control 1 = 0), and control 2 then holds the written low 16 bits with bit 0 forced to 1.
- R5: Writes to control 1 (0x20), control 3 (0x22), FIFO control (0x24), modulator (0x2A) and one-millisecond (0x2C) store the low 16 bits and read them back; control 2 stores the low 16 bits; a write to the increment word (0x29) stores its low 16 bits into the baud count read at 0x2B.
- R6: Writing ones to status 1 clears only bits under mask 0x9DB0 and to status 2 only bits under mask 0xBDD6; the ready, empty and line-state bits are unchanged.
- R7: A write to word 0x10 with control2 bit 2 set raises tx_valid for one cycle, starting the cycle after the write, carrying the written low byte; with bit 2 clear nothing is sent; status1 bit 13 stays set.
- R8: An offered character (rx_valid) is taken only while rx_ready is high; rx_ready equals NOT status1 bit 9. Taking it stores the character in bits 7:0 (a break event stores 0x0800 instead), sets status1 bit 9 and status2 bit 0 and clears test bit 5; an offer while full is dropped.
- R9: Reads of control 4 (0x23), the increment word (0x29) and unmapped word addresses, including any address with bits above bit 5 set, return 0; writes to 0x23, 0x2B and 0x2D change nothing.
- R10: With BOOT_ENABLE set (default), hardware reset leaves control 1 = 0x0001 (enable bit 0) and control 2 = 0x0005 (transmit enable bit 2), so a transmit write works with no setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the receive-data read side effect) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| rx_valid | input | 1 | Incoming character or break offered |
| rx_char | input | CHAR_W | Incoming character |
| rx_brk | input | 1 | Offer is a break event rather than a character |
| rx_ready | output | 1 | Holding word free, offer will be taken |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_char | output | CHAR_W | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a held character coinciding with a second offer and with a data read, since the holding word must drop the new offer yet release on the read. The bench walks all 256 character codes through offer, ignored second offer, peek and consuming read, and sweeps every combination of the three interrupt enables against an empty and a full holding word. A soft reset is issued while a character is held and several registers carry non-default values, so that every restored field is visible at once.

// File: rtl/serport_csr_pkg.sv
package serport_csr_pkg;

   // word indices
   localparam logic [5:0] A_RXD  = 6'h00;
   localparam logic [5:0] A_TXD  = 6'h10;
   localparam logic [5:0] A_CTL1 = 6'h20;
   localparam logic [5:0] A_CTL2 = 6'h21;
   localparam logic [5:0] A_CTL3 = 6'h22;
   localparam logic [5:0] A_CTL4 = 6'h23;
   localparam logic [5:0] A_FCTL = 6'h24;
   localparam logic [5:0] A_STS1 = 6'h25;
   localparam logic [5:0] A_STS2 = 6'h26;
   localparam logic [5:0] A_BINC = 6'h29;
   localparam logic [5:0] A_BMOD = 6'h2A;
   localparam logic [5:0] A_BCNT = 6'h2B;
   localparam logic [5:0] A_MSEC = 6'h2C;
   localparam logic [5:0] A_TEST = 6'h2D;

   // data word flags
   localparam int D_BRK = 11;
   localparam int D_ERR = 14;
   localparam int D_RDY = 15;

   // control bits
   localparam int C1_UARTEN = 0;
   localparam int C1_TXMTEN = 6;
   localparam int C1_RRDYEN = 9;
   localparam int C1_TRDYEN = 13;
   localparam int C2_SRST   = 0;
   localparam int C2_TXEN   = 2;

   // status bits
   localparam int S1_RRDY = 9;
   localparam int S1_TRDY = 13;
   localparam int S2_RDR  = 0;
   localparam int T_RXMT  = 5;
   localparam int T_TXMT  = 6;

   localparam logic [15:0] S1_CLR_MASK = 16'h9DB0;
   localparam logic [15:0] S2_CLR_MASK = 16'hBDD6;
   localparam logic [15:0] S1_DEFAULT  = 16'h6040;
   localparam logic [15:0] S2_DEFAULT  = 16'h4028;
   localparam logic [15:0] C3_DEFAULT  = 16'h0700;
   localparam logic [15:0] BC_DEFAULT  = 16'h0004;

   typedef enum logic {REG_PLAIN, REG_W1C} reg_kind_e;

endpackage

// File: rtl/serport_reg.sv
module serport_reg
   import serport_csr_pkg::*;
#(
   parameter int             W        = 16,
   parameter reg_kind_e      KIND     = REG_PLAIN,
   parameter logic [W-1:0]   HARD_RST = '0,
   parameter logic [W-1:0]   SOFT_RST = '0,
   parameter logic [W-1:0]   CLR_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("serport_reg: W must be positive");
   end

   // a write wins over soft clear; the only register written in the
   // soft-clear cycle is the one that triggers it
   if (KIND == REG_W1C) begin : g_w1c
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= HARD_RST;
         else if (wr)       q <= q & ~(wdata & CLR_MASK);
         else if (soft_clr) q <= SOFT_RST;
      end
   end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= HARD_RST;
         else if (wr)       q <= wdata;
         else if (soft_clr) q <= SOFT_RST;
      end
   end

endmodule

// File: rtl/serport_rx_hold.sv
module serport_rx_hold #(
   parameter int DATA_W  = 32,
   parameter int CHAR_W  = 8,
   parameter int BRK_BIT = 11,
   parameter int ERR_BIT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              offer,
   input  logic [CHAR_W-1:0] offer_char,
   input  logic              offer_brk,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] held
);

   localparam logic [DATA_W-1:0] ERR_WORD = DATA_W'(1) << ERR_BIT;
   localparam logic [DATA_W-1:0] BRK_WORD = DATA_W'(1) << BRK_BIT;

   if (CHAR_W > BRK_BIT) begin : g_bad_char
      $error("serport_rx_hold: character overlaps break flag");
   end

   logic accept;
   assign accept = offer && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         held <= ERR_WORD;
      end else if (soft_clr) begin
         full <= 1'b0;
         held <= ERR_WORD;
      end else if (accept) begin
         full <= 1'b1;
         held <= offer_brk ? BRK_WORD : DATA_W'(offer_char);
      end else if (take && full) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/serport_tx_path.sv
module serport_tx_path #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [CHAR_W-1:0] wchar,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_char
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_char  <= '0;
      end else begin
         tx_valid <= fire;
         if (fire) tx_char <= wchar;
      end
   end

endmodule

// File: rtl/serport_irq.sv
module serport_irq (
   input  logic sts_rrdy,
   input  logic sts_trdy,
   input  logic en_rrdy,
   input  logic en_trdy,
   input  logic en_txmt,
   output logic irq
);

   logic rx_term, tx_term;

   always_comb begin
      rx_term = sts_rrdy & en_rrdy;
      tx_term = sts_trdy & en_trdy & en_txmt;
      irq     = rx_term | tx_term;
   end

endmodule

// File: rtl/serport_csr.sv
module serport_csr
   import serport_csr_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int REG_W       = 16,
   parameter int CHAR_W      = 8,
   parameter bit BOOT_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              rx_brk,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_char,
   output logic              irq
);

   localparam int IDX_W = 6;
   localparam logic [REG_W-1:0] C1_SOFT = '0;
   localparam logic [REG_W-1:0] C1_HARD =
      BOOT_ENABLE ? REG_W'(1) << C1_UARTEN : '0;
   localparam logic [REG_W-1:0] C2_SOFT = REG_W'(1) << C2_SRST;
   localparam logic [REG_W-1:0] C2_HARD =
      BOOT_ENABLE ? (C2_SOFT | (REG_W'(1) << C2_TXEN)) : C2_SOFT;

   // elaboration checks
   if (REG_W != 16) begin : g_bad_reg
      $error("serport_csr: REG_W must be 16");
   end
   if (DATA_W < REG_W) begin : g_bad_data
      $error("serport_csr: DATA_W narrower than REG_W");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("serport_csr: ADDR_W below 6");
   end
   if (CHAR_W < 1 || CHAR_W > D_BRK) begin : g_bad_char
      $error("serport_csr: CHAR_W out of range");
   end

   // address decode
   logic [IDX_W-1:0] idx;
   logic             hi_zero;
   assign idx = bus_addr[IDX_W-1:0];

   if (ADDR_W > IDX_W) begin : g_hi
      assign hi_zero = ~|bus_addr[ADDR_W-1:IDX_W];
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   if (DATA_W > REG_W) begin : g_wide
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];
   end

   logic wr_hit;
   assign wr_hit = bus_wr && hi_zero;

   logic we_c1, we_c2, we_c3, we_fc, we_s1, we_s2, we_bi, we_bm, we_ms, we_tx;
   always_comb begin
      we_c1 = wr_hit && (idx == A_CTL1);
      we_c2 = wr_hit && (idx == A_CTL2);
      we_c3 = wr_hit && (idx == A_CTL3);
      we_fc = wr_hit && (idx == A_FCTL);
      we_s1 = wr_hit && (idx == A_STS1);
      we_s2 = wr_hit && (idx == A_STS2);
      we_bi = wr_hit && (idx == A_BINC);
      we_bm = wr_hit && (idx == A_BMOD);
      we_ms = wr_hit && (idx == A_MSEC);
      we_tx = wr_hit && (idx == A_TXD);
   end

   logic [REG_W-1:0] wlow;
   logic             soft_clr;
   assign wlow     = bus_wdata[REG_W-1:0];
   assign soft_clr = we_c2 && !wlow[C2_SRST];

   // register slices
   logic [REG_W-1:0] c1_q, c2_q, c3_q, fc_q, s1_q, s2_q, bc_q, bm_q, ms_q;

   serport_reg #(.W(REG_W), .KIND(REG_PLAIN), .HARD_RST(C1_HARD), .SOFT_RST(C1_SOFT))
      u_ctl1 (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_c1), .wdata(wlow), .q(c1_q));

   serport_reg #(.W(REG_W), .KIND(REG_PLAIN), .HARD_RST(C2_HARD), .SOFT_RST(C2_SOFT))
      u_ctl2 (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_c2),
              .wdata(wlow | C2_SOFT & {REG_W{soft_clr}}), .q(c2_q));

   serport_reg #(.W(REG_W), .KIND(REG_PLAIN), .HARD_RST(REG_W'(C3_DEFAULT)), .SOFT_RST(REG_W'(C3_DEFAULT)))
      u_ctl3 (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_c3), .wdata(wlow), .q(c3_q));

   serport_reg #(.W(REG_W), .KIND(REG_PLAIN))
      u_fctl (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_fc), .wdata(wlow), .q(fc_q));

   serport_reg #(.W(REG_W), .KIND(REG_PLAIN), .HARD_RST(REG_W'(BC_DEFAULT)), .SOFT_RST(REG_W'(BC_DEFAULT)))
      u_bcnt (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_bi), .wdata(wlow), .q(bc_q));

   serport_reg #(.W(REG_W), .KIND(REG_PLAIN))
      u_bmod (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_bm), .wdata(wlow), .q(bm_q));

   serport_reg #(.W(REG_W), .KIND(REG_PLAIN))
      u_msec (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_ms), .wdata(wlow), .q(ms_q));

   serport_reg #(.W(REG_W), .KIND(REG_W1C), .HARD_RST(REG_W'(S1_DEFAULT)),
                 .SOFT_RST(REG_W'(S1_DEFAULT)), .CLR_MASK(REG_W'(S1_CLR_MASK)))
      u_sts1 (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_s1), .wdata(wlow), .q(s1_q));

   serport_reg #(.W(REG_W), .KIND(REG_W1C), .HARD_RST(REG_W'(S2_DEFAULT)),
                 .SOFT_RST(REG_W'(S2_DEFAULT)), .CLR_MASK(REG_W'(S2_CLR_MASK)))
      u_sts2 (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(we_s2), .wdata(wlow), .q(s2_q));

   // receive holding word
   logic              rx_full;
   logic [DATA_W-1:0] rx_word;
   logic              rd_take;
   assign rd_take = bus_rd && hi_zero && (idx == A_RXD);

   serport_rx_hold #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .BRK_BIT(D_BRK), .ERR_BIT(D_ERR))
      u_rx (.clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .offer(rx_valid),
            .offer_char(rx_char), .offer_brk(rx_brk), .take(rd_take),
            .full(rx_full), .held(rx_word));

   assign rx_ready = !rx_full;

   // transmit path
   serport_tx_path #(.CHAR_W(CHAR_W))
      u_tx (.clk(clk), .rst_n(rst_n), .fire(we_tx && c2_q[C2_TXEN]),
            .wchar(bus_wdata[CHAR_W-1:0]), .tx_valid(tx_valid), .tx_char(tx_char));

   // live status views
   logic [REG_W-1:0] s1_view, s2_view, test_view;
   always_comb begin
      s1_view          = s1_q;
      s1_view[S1_RRDY] = s1_q[S1_RRDY] | rx_full;
      s2_view          = s2_q;
      s2_view[S2_RDR]  = s2_q[S2_RDR] | rx_full;
      test_view        = '0;
      test_view[T_RXMT] = !rx_full;
      test_view[T_TXMT] = 1'b1;
   end

   serport_irq u_irq (
      .sts_rrdy(s1_view[S1_RRDY]), .sts_trdy(s1_view[S1_TRDY]),
      .en_rrdy(c1_q[C1_RRDYEN]), .en_trdy(c1_q[C1_TRDYEN]), .en_txmt(c1_q[C1_TXMTEN]),
      .irq(irq));

   // read mux
   logic [DATA_W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      if (hi_zero) begin
         case (idx)
            A_RXD:  rd_word = rx_word | ((DATA_W'(rx_full)) << D_RDY);
            A_CTL1: rd_word = DATA_W'(c1_q);
            A_CTL2: rd_word = DATA_W'(c2_q);
            A_CTL3: rd_word = DATA_W'(c3_q);
            A_FCTL: rd_word = DATA_W'(fc_q);
            A_STS1: rd_word = DATA_W'(s1_view);
            A_STS2: rd_word = DATA_W'(s2_view);
            A_BMOD: rd_word = DATA_W'(bm_q);
            A_BCNT: rd_word = DATA_W'(bc_q);
            A_MSEC: rd_word = DATA_W'(ms_q);
            A_TEST: rd_word = DATA_W'(test_view);
            default: rd_word = '0;
         endcase
      end
   end
   assign bus_rdata = rd_word;

endmodule

// File: rtl/serport_csr_chk.sv
module serport_csr_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic              irq
);

   logic at_rxd, at_ctl1, at_ctl2, at_sts1, at_txd;
   assign at_rxd  = (bus_addr == ADDR_W'(6'h00));
   assign at_txd  = (bus_addr == ADDR_W'(6'h10));
   assign at_ctl1 = (bus_addr == ADDR_W'(6'h20));
   assign at_ctl2 = (bus_addr == ADDR_W'(6'h21));
   assign at_sts1 = (bus_addr == ADDR_W'(6'h25));

   // R3: char-ready flag tracks the handshake ready output
   p_charrdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      at_rxd |-> (bus_rdata[15] == !rx_ready));

   // R3: a consuming read frees the holding word
   p_read_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && at_rxd && !rx_ready) |=> rx_ready);

   // R8: an accepted offer fills the holding word
   p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && !(bus_wr && at_ctl2)) |=> !rx_ready);

   // R7: transmit strobe only follows a transmit-port write
   p_tx_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(bus_wr && at_txd));

   // R7: transmit-ready never drops
   p_trdy_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      at_sts1 |-> bus_rdata[13]);

   // R2: held character with its enable raises the interrupt
   p_irq_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ready && at_ctl1 && bus_rdata[9]) |-> irq);

endmodule

bind serport_csr serport_csr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
   .tx_valid(tx_valid), .irq(irq));

// File: tb/serport_csr_tb.sv
`timescale 1ns/1ps
module serport_csr_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0, rx_brk = 1'b0;
   logic [7:0]  rx_char = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_char;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   serport_csr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_char(rx_char),
      .rx_brk(rx_brk), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_char(tx_char), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic offer(input logic [7:0] c, input logic b);
      @(negedge clk);
      rx_valid = 1'b1; rx_char = c; rx_brk = b;
      @(negedge clk);
      rx_valid = 1'b0; rx_brk = 1'b0;
   endtask

   function automatic logic [31:0] boot_val(input int i);
      case (i)
         'h00: return 32'h4000;
         'h20: return 32'h0001;
         'h21: return 32'h0005;
         'h22: return 32'h0700;
         'h25: return 32'h6040;
         'h26: return 32'h4028;
         'h2B: return 32'h0004;
         'h2D: return 32'h0060;
         default: return 32'h0;
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R10: reset state of the outputs and the full word space
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
      chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
      for (int i = 0; i < 64; i++) begin
         peek(8'(i), v);
         chk($sformatf("R1/R10/R9 reset word 0x%02h", i), v, boot_val(i));
      end
      // R9: upper address bits make any word unmapped
      for (int i = 1; i < 4; i++) begin
         peek(8'(i * 64 + 'h25), v);
         chk("R9 aliased high address", v, 32'h0);
      end

      // R10: transmit works straight out of reset
      wr(8'h10, 32'h0000_015A);
      chk("R10 tx_valid", {31'b0, tx_valid}, 32'h1);
      chk("R10 tx_char", {24'b0, tx_char}, 32'h5A);
      @(negedge clk);
      chk("R7 single pulse", {31'b0, tx_valid}, 32'h0);

      // R7: all byte values, then the disabled case
      for (int c = 0; c < 256; c++) begin
         wr(8'h10, 32'hABCD_0000 | 32'(c) << 0 | 32'h300);
         chk("R7 tx_valid", {31'b0, tx_valid}, 32'h1);
         chk("R7 tx_char", {24'b0, tx_char}, 32'(c));
      end
      wr(8'h21, 32'h0000_0003);
      wr(8'h10, 32'h0000_0077);
      chk("R7 gated by enable", {31'b0, tx_valid}, 32'h0);
      @(negedge clk);
      chk("R7 still quiet", {31'b0, tx_valid}, 32'h0);
      peek(8'h25, v);
      chk("R7 trdy kept", v, 32'h6040);
      wr(8'h21, 32'h0000_0005);

      // R5: store and read back low 16 bits
      begin
         logic [7:0]  regs [5] = '{8'h20, 8'h22, 8'h24, 8'h2A, 8'h2C};
         logic [31:0] pats [4] = '{32'hA5A5_1234, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_C3C3};
         foreach (regs[r]) begin
            foreach (pats[p]) begin
               wr(regs[r], pats[p]);
               peek(regs[r], v);
               chk($sformatf("R5 word 0x%02h", regs[r]), v, pats[p] & 32'hFFFF);
            end
         end
      end
      wr(8'h20, 32'h0);
      wr(8'h21, 32'hFFFF_8005);
      peek(8'h21, v);
      chk("R5 control2 low bits", v, 32'h8005);
      wr(8'h29, 32'h0001_BEEF);
      peek(8'h2B, v);
      chk("R5 increment into count", v, 32'hBEEF);
      peek(8'h29, v);
      chk("R9 increment reads zero", v, 32'h0);

      // R9: ignored writes
      wr(8'h23, 32'hFFFF_FFFF);
      peek(8'h23, v);
      chk("R9 control4 reads zero", v, 32'h0);
      wr(8'h2D, 32'h0000_FFFF);
      peek(8'h2D, v);
      chk("R9 test register unchanged", v, 32'h0060);
      wr(8'h2B, 32'h0000_1111);
      peek(8'h2B, v);
      chk("R9 count not writable directly", v, 32'hBEEF);

      // R6: write-one-to-clear leaves live and line bits
      wr(8'h25, 32'hFFFF_FFFF);
      peek(8'h25, v);
      chk("R6 status1 after ones", v, 32'h6040);
      wr(8'h26, 32'hFFFF_FFFF);
      peek(8'h26, v);
      chk("R6 status2 after ones", v, 32'h4028);

      // R8 R3: every character through the holding word
      for (int c = 0; c < 256; c++) begin
         offer(8'(c), 1'b0);
         chk("R8 rx_ready low when held", {31'b0, rx_ready}, 32'h0);
         offer(8'(c ^ 8'hFF), 1'b0);
         peek(8'h00, v);
         chk("R8/R3 held with ready flag, second offer dropped", v, 32'h8000 | 32'(c));
         if (c == 17) begin
            peek(8'h25, v); chk("R8 status1 full", v, 32'h6240);
            peek(8'h26, v); chk("R8 status2 full", v, 32'h4029);
            peek(8'h2D, v); chk("R8 test full", v, 32'h0040);
            wr(8'h25, 32'hFFFF_FFFF);
            wr(8'h26, 32'hFFFF_FFFF);
            peek(8'h25, v); chk("R6 status1 ready kept", v, 32'h6240);
            peek(8'h26, v); chk("R6 status2 ready kept", v, 32'h4029);
         end
         rd(8'h00, v);
         chk("R3 consuming read value", v, 32'h8000 | 32'(c));
         chk("R3 rx_ready after read", {31'b0, rx_ready}, 32'h1);
         peek(8'h00, v);
         chk("R3 reread without flag", v, 32'(c));
      end
      peek(8'h2D, v);
      chk("R3 receive-empty set", v, 32'h0060);
      offer(8'h41, 1'b1);
      peek(8'h00, v);
      chk("R8 break word", v, 32'h8800);
      rd(8'h00, v);

      // R2: interrupt over all enable combinations, empty and full
      for (int e = 0; e < 8; e++) begin
         for (int f = 0; f < 2; f++) begin
            logic b13, b6, b9, exp_irq;
            b13 = e[0]; b6 = e[1]; b9 = e[2];
            wr(8'h20, (32'(b13) << 13) | (32'(b6) << 6) | (32'(b9) << 9));
            if (f == 1) offer(8'h33, 1'b0);
            exp_irq = (b13 & b6) | (f[0] & b9);
            #1 chk($sformatf("R2 irq en=%0d full=%0d", e, f), {31'b0, irq}, {31'b0, exp_irq});
            if (f == 1) rd(8'h00, v);
         end
      end

      // R4: soft reset while populated
      wr(8'h20, 32'h0000_1234);
      wr(8'h22, 32'h0000_0055);
      wr(8'h24, 32'h0000_00AA);
      wr(8'h2A, 32'h0000_0101);
      wr(8'h2C, 32'h0000_0202);
      offer(8'h99, 1'b0);
      wr(8'h21, 32'h0000_0006);
      for (int i = 0; i < 64; i++) begin
         logic [31:0] e;
         e = boot_val(i);
         if (i == 'h20) e = 32'h0;
         if (i == 'h21) e = 32'h0007;
         peek(8'(i), v);
         chk($sformatf("R4 soft default 0x%02h", i), v, e);
      end
      chk("R4 rx_ready restored", {31'b0, rx_ready}, 32'h1);
      chk("R4 irq low", {31'b0, irq}, 32'h0);

      finish_run();
   end

endmodule